// File: doc/BRIEF.md
# Coin-Operated Newspaper Vending Controller

This block is the control core of a paper-vending machine where one paper costs 15 units. Two one-cycle strobes report an inserted coin: one for a 5-unit coin and one for a 10-unit coin. The controller adds up the credit paid so far. When a coin brings the total to the price or beyond, it raises a one-cycle vend pulse and then starts the next sale from zero.

If a buyer overpays, for example with two 10-unit coins, the paper is still released. The surplus is kept and no change is returned. Inside the block, credit is counted in steps of the smallest coin, so only the values 0, 5 and 10 are ever held between sales. When both strobes arrive in the same cycle, the input is ambiguous, so the controller discards that cycle. It does nothing with coin validation, change-making or item selection.

Top module: `paper_vendor`

## Requirements
- R1: A synchronous active-high reset clears the held credit to 0 and holds `vend` low, even when a coin strobe is asserted in the reset cycle.
- R2: Three 5-unit coins in a row release one paper, and the vend pulse follows the third coin.
- R3: A 5-unit coin followed by a 10-unit coin releases a paper. A 10-unit coin followed by a 5-unit coin also releases a paper.
- R4: Two 10-unit coins release a paper, and the surplus 5 units are dropped. After any release, credit restarts at 0, so a single 10-unit coin alone does not release a second paper.
- R5: `vend` is registered. It is high for exactly the one cycle after the clock edge that samples the qualifying coin, and low again in the following cycle.
- R6: A cycle in which `coin5` and `coin10` are both high is ignored: no release, and the held credit is unchanged.
- R7: In a cycle with no coin strobe, the credit is held and `vend` stays low.
- R8: Credit that is below the price (5 or 10 units) never releases a paper, however long it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin5 | input | 1 | One-cycle strobe: a 5-unit coin was inserted |
| coin10 | input | 1 | One-cycle strobe: a 10-unit coin was inserted |
| vend | output | 1 | One-cycle pulse that releases one paper |

## Verification
The bench targets the overpay path (two 10-unit coins):
- A design that saturates credit or carries the surplus forward would release a second paper after the next single 10-unit coin.

It drives both strobes in the same cycle, from zero credit and from 5 units of credit:
- A design that treats this as a 5-unit coin would release one coin early.
- A design that treats it as a 10-unit coin would release at once.

It parks credit at 10 through idle cycles, which catches a controller that leaks or releases on a held state. A reset that arrives together with a coin checks that reset takes priority and that no stale credit survives.

// File: rtl/paper_vendor_pkg.sv
package paper_vendor_pkg;

    // Decoded coin event for one cycle.
    typedef enum logic [1:0] {
        CE_NONE  = 2'd0,
        CE_SMALL = 2'd1,
        CE_BIG   = 2'd2
    } coin_evt_e;

    // Integer ceiling division used to derive step counts.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Width large enough to hold values 0..max_val.
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/coin_sense.sv
module coin_sense
    import paper_vendor_pkg::*;
(
    input  logic      small_strobe,
    input  logic      big_strobe,
    output coin_evt_e evt
);
    // Exactly one strobe is a valid coin; both together are discarded.
    always_comb begin
        unique case ({small_strobe, big_strobe})
            2'b10:   evt = CE_SMALL;
            2'b01:   evt = CE_BIG;
            default: evt = CE_NONE;
        endcase
    end
endmodule

// File: rtl/credit_tally.sv
module credit_tally
    import paper_vendor_pkg::*;
#(
    parameter int PRICE_STEPS = 3,
    parameter int BIG_STEPS   = 2,
    parameter int CREDIT_W    = 2,
    parameter int SUM_W       = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  coin_evt_e           evt,
    output logic [CREDIT_W-1:0] credit,
    output logic                reached
);
    logic [SUM_W-1:0] add_steps;
    logic [SUM_W-1:0] sum;

    always_comb begin
        unique case (evt)
            CE_SMALL: add_steps = SUM_W'(1);
            CE_BIG:   add_steps = SUM_W'(BIG_STEPS);
            default:  add_steps = '0;
        endcase
        sum     = SUM_W'(credit) + add_steps;
        reached = (evt != CE_NONE) && (sum >= SUM_W'(PRICE_STEPS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
        end else if (reached) begin
            credit <= '0;  // surplus is dropped, next sale starts empty
        end else begin
            credit <= sum[CREDIT_W-1:0];
        end
    end
endmodule

// File: rtl/vend_pulse.sv
module vend_pulse (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end
endmodule

// File: rtl/paper_vendor.sv
module paper_vendor
    import paper_vendor_pkg::*;
#(
    parameter int PRICE      = 15,
    parameter int SMALL_COIN = 5,
    parameter int BIG_COIN   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic coin5,
    input  logic coin10,
    output logic vend
);
    localparam int PRICE_STEPS = ceil_div(PRICE, SMALL_COIN);
    localparam int BIG_STEPS   = BIG_COIN / SMALL_COIN;
    localparam int CREDIT_W    = width_for(PRICE_STEPS - 1);
    localparam int SUM_W       = width_for(PRICE_STEPS - 1 + BIG_STEPS);

    coin_evt_e           evt;
    logic [CREDIT_W-1:0] credit_q;
    logic                reached;

    coin_sense i_sense (
        .small_strobe (coin5),
        .big_strobe   (coin10),
        .evt          (evt)
    );

    credit_tally #(
        .PRICE_STEPS (PRICE_STEPS),
        .BIG_STEPS   (BIG_STEPS),
        .CREDIT_W    (CREDIT_W),
        .SUM_W       (SUM_W)
    ) i_tally (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .credit  (credit_q),
        .reached (reached)
    );

    vend_pulse i_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (reached),
        .pulse (vend)
    );
endmodule

// File: rtl/paper_vendor_checker.sv
module paper_vendor_checker #(
    parameter int PRICE_STEPS = 3,
    parameter int CREDIT_W    = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                coin5,
    input logic                coin10,
    input logic                vend,
    input logic [CREDIT_W-1:0] credit
);
    // R1: reset empties credit and keeps vend low
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!vend && credit == '0));

    // R5: vend never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vend |=> !vend);

    // R6: both strobes at once change nothing
    a_r6_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (coin5 && coin10) |=> (!vend && $stable(credit)));

    // R7: idle cycle holds credit, no vend
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!coin5 && !coin10) |=> (!vend && $stable(credit)));

    // R4: after a release the next sale starts at zero
    a_r4_restart_empty: assert property (@(posedge clk) disable iff (rst)
        vend |-> credit == '0);

    // R2: every vend is preceded by exactly one valid coin
    a_r2_vend_has_coin: assert property (@(posedge clk) disable iff (rst)
        vend |-> $past(coin5 ^ coin10));

    // R8: held credit always stays under the price
    a_r8_below_price: assert property (@(posedge clk) disable iff (rst)
        32'(credit) < PRICE_STEPS);
endmodule

bind paper_vendor paper_vendor_checker #(
    .PRICE_STEPS (PRICE_STEPS),
    .CREDIT_W    (CREDIT_W)
) i_checker (
    .clk    (clk),
    .rst    (rst),
    .coin5  (coin5),
    .coin10 (coin10),
    .vend   (vend),
    .credit (credit_q)
);

// File: tb/test_paper_vendor.sv
`timescale 1ns/1ps
module test_paper_vendor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin5 = 1'b0;
    logic coin10 = 1'b0;
    logic vend;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    paper_vendor i_paper_vendor (
        .clk    (clk),
        .rst    (rst),
        .coin5  (coin5),
        .coin10 (coin10),
        .vend   (vend)
    );

    // {coin5, coin10, expected vend after the edge, requirement number}
    localparam int NVEC = 29;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1_0_0_0010, 7'b1_0_0_0010, 7'b1_0_1_0010, 7'b0_0_0_0101,  // R2, R5
        7'b1_0_0_0011, 7'b0_1_1_0011, 7'b0_0_0_0101,                 // R3, R5
        7'b0_1_0_0011, 7'b1_0_1_0011,                                // R3
        7'b0_1_0_0100, 7'b0_1_1_0100, 7'b0_1_0_0100, 7'b1_0_1_0100,  // R4
        7'b0_0_0_0111, 7'b1_0_0_0111, 7'b0_0_0_0111, 7'b0_0_0_0111,
        7'b0_1_1_0111,                                               // R7
        7'b1_0_0_0110, 7'b1_1_0_0110, 7'b1_0_0_0110, 7'b1_0_1_0110,  // R6
        7'b1_1_0_0110, 7'b0_1_0_0110, 7'b1_1_0_0110, 7'b1_0_1_0110,  // R6
        7'b0_1_0_1000, 7'b0_0_0_1000, 7'b1_0_1_1000                  // R8
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (vend !== exp) begin
            failures++;
            $display("FAIL %s: vend=%b expected=%b at %0t", req, vend, exp, $time);
        end
    endtask

    // Drive at negedge, sample 1 ns after the next rising edge.
    task automatic step(input logic s, input logic b, input logic exp, input string req);
        @(negedge clk);
        coin5  = s;
        coin10 = b;
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, "R1");  // reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
        end

        // R1: reset mid-sale, coin in the reset cycle must be dropped
        step(1'b0, 1'b1, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b1;
        coin5 = 1'b0;
        coin10 = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        coin10 = 1'b0;
        step(1'b0, 1'b1, 1'b0, "R1");  // credit was cleared: 10 alone is short
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b0, "R5");

        // R8: credit 5 held for many idle cycles never vends
        step(1'b1, 1'b0, 1'b0, "R8");
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b1, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule